// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block resolves register data hazards in a five-stage integer pipeline (fetch, decode, execute, memory, writeback). It compares the source register numbers of the instructions in decode and execute with the destination numbers of older instructions further down the pipe. From these comparisons it produces two 2-bit select codes for the multiplexers in front of the two ALU inputs. It also raises a stall when a load is followed directly by an instruction that consumes its result.

A stall freezes the program counter and the fetch/decode register. It also clears the write and load controls of the instruction entering execute, so a no-op bubble moves down the pipe. One such cycle is enough. After it, the loaded data reaches the writeback stage and is bypassed from there.

For test, the block contains a small harness of pipeline registers that carry only the hazard-relevant fields: source numbers, destination number, a register-write flag and a memory-read flag. Each cycle the environment presents the fields of the instruction being fetched. Register 0 is hard-wired to zero, so it never creates a dependency.

Top module: `fwd_stall_core`

## Requirements
- R1: `fwd_a` is 2'b10 (take the execute/memory result) when the execute/memory stage writes a register, its destination is not 0, and that destination equals the first source of the execute-stage instruction.
- R2: `fwd_b` is 2'b10 under the same condition, applied to the second source of the execute-stage instruction.
- R3: A select code is 2'b01 (take the memory/writeback result) when the memory/writeback stage writes a nonzero destination equal to that operand's source, and the R1/R2 condition for that operand does not hold.
- R4: When both older stages write the same register that an operand reads, the select code is 2'b10, so the newer result wins.
- R5: Source or destination register 0 never produces a select code other than 2'b00 and never causes a stall.
- R6: In every other case the select code is 2'b00, meaning the register-file value is used.
- R7: `stall` is 1 in the same cycle in which the execute-stage instruction reads memory, its second source (the load target) is nonzero, and that register equals either source of the decode-stage instruction.
- R8: `pc_we` and `ifid_we` are the inverse of `stall`. While `stall` is 1, the decode-stage instruction is held, and it is evaluated again in the next cycle.
- R9: A stall inserts a bubble into the execute stage that carries no write and no load control. The bubble therefore forwards nothing and never causes a second stall.
- R10: After a single stall cycle, the dependent instruction reaches execute with the load in memory/writeback, and its select code for that operand is 2'b01.
- R11: While reset is applied, all pipeline controls are cleared. Both select codes are 2'b00, `stall` is 0, and both write enables are 1.
- R12: `rst_n` is active low. Asserting it clears the pipeline state at once, without waiting for a clock edge. Its release takes effect only after two rising clock edges.

Active hazard output for the `fwd_a` and `fwd_b` encoding: 00 register file, 01 memory/writeback, 10 execute/memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fe_rs | input | 5 | First source of the instruction being fetched |
| fe_rt | input | 5 | Second source (load target for loads) of the fetched instruction |
| fe_dst | input | 5 | Destination register of the fetched instruction |
| fe_wr | input | 1 | Fetched instruction writes a register |
| fe_ld | input | 1 | Fetched instruction reads data memory |
| fwd_a | output | 2 | Select code for ALU input A |
| fwd_b | output | 2 | Select code for ALU input B |
| stall | output | 1 | Load-use interlock active |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |

## Verification
Directed streams place a producer one and two slots ahead of its consumer, on each operand in turn. This separates the execute/memory path from the memory/writeback path. A run of three instructions that all rewrite the same register isolates the newer-wins priority, and producers that target register 0 or write nothing show that no false bypass occurs. Load-use pairs on each source, and a load whose target the stalled instruction also rewrites, show that the bubble is empty, that the stall lasts a single cycle, and that the loaded value later comes from writeback. A long pseudo-random stream over eight registers then mixes all cases against the behavioural model.

// File: rtl/hz_pkg.sv
package hz_pkg;
  parameter int REG_AW = 5;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_t;

  typedef struct packed {
    logic [REG_AW-1:0] rs;
    logic [REG_AW-1:0] rt;
    logic [REG_AW-1:0] dst;
    logic              wr;
    logic              ld;
  } stage_t;
endpackage

// File: rtl/hz_rst_sync.sv
module hz_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/hz_stage_reg.sv
module hz_stage_reg
  import hz_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   kill,
  input  stage_t d,
  output stage_t q
);
  stage_t nxt;

  always_comb begin
    nxt = q;
    if (en) begin
      nxt = d;
      if (kill) begin
        nxt.wr = 1'b0;
        nxt.ld = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
(
  input  logic [REG_AW-1:0] src,
  input  stage_t            exm,
  input  stage_t            mwb,
  output fwd_sel_t          sel
);
  logic ex_hit;
  logic wb_hit;

  always_comb begin
    ex_hit = exm.wr && (exm.dst != '0) && (exm.dst == src);
    wb_hit = mwb.wr && (mwb.dst != '0) && (mwb.dst == src);
    if (ex_hit)      sel = SEL_MEM;
    else if (wb_hit) sel = SEL_WB;
    else             sel = SEL_RF;
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
  import hz_pkg::*;
(
  input  stage_t dec,
  input  stage_t exe,
  output logic   hold
);
  logic tgt_live;

  always_comb begin
    tgt_live = exe.ld && (exe.rt != '0);
    hold     = tgt_live && ((exe.rt == dec.rs) || (exe.rt == dec.rt));
  end
endmodule

// File: rtl/fwd_stall_core.sv
module fwd_stall_core
  import hz_pkg::*;
#(
  parameter int NSTG     = 4,
  parameter int NOPS     = 2,
  parameter int RST_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] fe_rs,
  input  logic [REG_AW-1:0] fe_rt,
  input  logic [REG_AW-1:0] fe_dst,
  input  logic              fe_wr,
  input  logic              fe_ld,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              stall,
  output logic              pc_we,
  output logic              ifid_we
);
  localparam int ST_IFID  = 0;
  localparam int ST_IDEX  = 1;
  localparam int ST_EXMEM = 2;
  localparam int ST_MEMWB = 3;

  logic     rst_int_n;
  stage_t   stg_d   [NSTG];
  stage_t   stg_q   [NSTG];
  logic     stg_en  [NSTG];
  logic     stg_kill[NSTG];
  fwd_sel_t sel_w   [NOPS];
  logic [REG_AW-1:0] op_src [NOPS];
  stage_t   ifid_q, idex_q, exmem_q, memwb_q;
  logic     hold_w;

  hz_rst_sync #(.STAGES(RST_SYNC)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_int_n)
  );

  always_comb begin
    stg_d[0] = '{rs: fe_rs, rt: fe_rt, dst: fe_dst, wr: fe_wr, ld: fe_ld};
    for (int i = 1; i < NSTG; i++) stg_d[i] = stg_q[i-1];
    for (int i = 0; i < NSTG; i++) begin
      stg_en[i]   = (i == ST_IFID) ? !hold_w : 1'b1;
      stg_kill[i] = (i == ST_IDEX) ? hold_w  : 1'b0;
    end
  end

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    hz_stage_reg u_stg (
      .clk   (clk),
      .rst_n (rst_int_n),
      .en    (stg_en[g]),
      .kill  (stg_kill[g]),
      .d     (stg_d[g]),
      .q     (stg_q[g])
    );
  end

  assign ifid_q  = stg_q[ST_IFID];
  assign idex_q  = stg_q[ST_IDEX];
  assign exmem_q = stg_q[ST_EXMEM];
  assign memwb_q = stg_q[ST_MEMWB];

  hz_load_use u_lu (
    .dec  (ifid_q),
    .exe  (idex_q),
    .hold (hold_w)
  );

  assign op_src[0] = idex_q.rs;
  assign op_src[1] = idex_q.rt;

  for (genvar op = 0; op < NOPS; op++) begin : g_op
    hz_fwd_sel u_sel (
      .src (op_src[op]),
      .exm (exmem_q),
      .mwb (memwb_q),
      .sel (sel_w[op])
    );
  end

  assign fwd_a   = sel_w[0];
  assign fwd_b   = sel_w[1];
  assign stall   = hold_w;
  assign pc_we   = !hold_w;
  assign ifid_we = !hold_w;
endmodule

// File: rtl/fwd_stall_checker.sv
module fwd_stall_checker
  import hz_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       stall,
  input logic [1:0] fwd_a,
  input stage_t     ifid_q,
  input stage_t     idex_q,
  input stage_t     exmem_q
);
  AST_IFID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(ifid_q)); // R8

  AST_BUBBLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!idex_q.wr && !idex_q.ld)); // R9

  AST_SINGLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall); // R9

  AST_REG0_NO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_q.rs == '0) |-> (fwd_a == 2'b00)); // R5

  AST_NEWER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (exmem_q.wr && (exmem_q.dst == idex_q.rs) && (idex_q.rs != '0)) |-> (fwd_a == 2'b10)); // R4
endmodule

bind fwd_stall_core fwd_stall_checker i_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .stall   (stall),
  .fwd_a   (fwd_a),
  .ifid_q  (ifid_q),
  .idex_q  (idex_q),
  .exmem_q (exmem_q)
);

// File: tb/test_fwd_stall_core.sv
`timescale 1ns/1ps
module test_fwd_stall_core;
  typedef struct {
    int rs; int rt; int dst; bit wr; bit ld; bit bub;
  } m_t;

  logic       clk;
  logic       rst_n;
  logic [4:0] fe_rs, fe_rt, fe_dst;
  logic       fe_wr, fe_ld;
  logic [1:0] fwd_a, fwd_b;
  logic       stall, pc_we, ifid_we;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  m_t st[4];
  m_t prog[$];
  int pc = 0;
  int unsigned seed = 32'h1234_5678;

  fwd_stall_core i_fwd_stall_core (
    .clk(clk), .rst_n(rst_n),
    .fe_rs(fe_rs), .fe_rt(fe_rt), .fe_dst(fe_dst), .fe_wr(fe_wr), .fe_ld(fe_ld),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .pc_we(pc_we), .ifid_we(ifid_we)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic add(int rs, int rt, int dst, bit wr, bit ld);
    m_t m;
    m = '{rs: rs, rt: rt, dst: dst, wr: wr, ld: ld, bub: 1'b0};
    prog.push_back(m);
  endtask

  function automatic m_t nop_m();
    return '{rs: 0, rt: 0, dst: 0, wr: 1'b0, ld: 1'b0, bub: 1'b0};
  endfunction

  function automatic bit hits(m_t p, int src);
    return p.wr && (p.dst != 0) && (p.dst == src);
  endfunction

  function automatic int exp_sel(int src);
    if (hits(st[2], src)) return 2;
    if (hits(st[3], src)) return 1;
    return 0;
  endfunction

  function automatic string sel_tag(int src, bit opb);
    int e;
    e = exp_sel(src);
    if (src == 0) return "R5";
    if (hits(st[2], src) && hits(st[3], src)) return "R4";
    if (e == 2) return opb ? "R2" : "R1";
    if (e == 1) return st[3].ld ? "R10" : "R3";
    return "R6";
  endfunction

  function automatic bit exp_stall();
    return st[1].ld && (st[1].rt != 0) && (st[1].rt == st[0].rs || st[1].rt == st[0].rt);
  endfunction

  function automatic string stall_tag();
    if (st[1].bub) return "R9";
    if (st[1].ld && st[1].rt == 0) return "R5";
    return "R7";
  endfunction

  task automatic drive(m_t m);
    fe_rs = m.rs[4:0]; fe_rt = m.rt[4:0]; fe_dst = m.dst[4:0];
    fe_wr = m.wr; fe_ld = m.ld;
  endtask

  function automatic m_t cur_fetch();
    if (pc < prog.size()) return prog[pc];
    return nop_m();
  endfunction

  // one cycle: compare at negedge, step model, advance fetch after edge
  task automatic step();
    bit se;
    m_t f;
    @(negedge clk);
    se = exp_stall();
    chk(sel_tag(st[1].rs, 1'b0), fwd_a, exp_sel(st[1].rs));
    chk(sel_tag(st[1].rt, 1'b1), fwd_b, exp_sel(st[1].rt));
    chk(stall_tag(), stall, se);
    chk("R8", pc_we, !se);
    chk("R8", ifid_we, !se);
    f = cur_fetch();
    st[3] = st[2];
    st[2] = st[1];
    if (se) begin
      st[1] = st[0];
      st[1].wr = 1'b0; st[1].ld = 1'b0; st[1].bub = 1'b1;
    end else begin
      st[1] = st[0];
      st[0] = f;
    end
    @(posedge clk);
    #1;
    if (!se) pc++;
    drive(cur_fetch());
  endtask

  function automatic int rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % 8);
  endfunction

  initial begin
    rst_n = 1'b0;
    drive(nop_m());
    for (int i = 0; i < 4; i++) st[i] = nop_m();

    // back-to-back and distance-two on both operands
    add(1, 2, 3, 1, 0);
    add(3, 4, 5, 1, 0);
    add(6, 3, 7, 1, 0);
    add(5, 5, 8, 1, 0);
    add(0, 0, 9, 1, 0);
    add(2, 9, 10, 1, 0);
    // triple rewrite of one register: newer wins
    add(1, 1, 1, 1, 0);
    add(1, 1, 1, 1, 0);
    add(1, 1, 1, 1, 0);
    // register 0 as destination and as load target
    add(1, 2, 0, 1, 0);
    add(0, 0, 11, 1, 0);
    add(4, 0, 0, 1, 1);
    add(0, 0, 12, 1, 0);
    // load-use on first source, consumer rewrites same register
    add(1, 5, 5, 1, 1);
    add(5, 5, 5, 1, 0);
    add(5, 6, 13, 1, 0);
    // load-use on second source
    add(2, 6, 6, 1, 1);
    add(2, 6, 14, 1, 0);
    // independent load then distance-two use
    add(3, 7, 7, 1, 1);
    add(1, 2, 15, 1, 0);
    add(7, 0, 16, 1, 0);
    // producer that does not write
    add(3, 4, 17, 0, 0);
    add(17, 17, 18, 1, 0);
    // pseudo-random mix over eight registers
    for (int i = 0; i < 200; i++) begin
      bit ld_i;
      int t;
      ld_i = (rnd8() < 2);
      t = rnd8();
      add(rnd8(), t, ld_i ? t : rnd8(), ld_i || (rnd8() != 0), ld_i);
    end

    // R11: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R11", fwd_a, 0);
    chk("R11", fwd_b, 0);
    chk("R11", stall, 0);
    chk("R11", pc_we, 1);
    chk("R11", ifid_we, 1);
    rst_n = 1'b1;
    pc = -4;   // idle nops while reset release ripples through
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1; pc++;
    end
    drive(cur_fetch());
    while (pc < prog.size() + 4) step();

    // R12: asynchronous assertion clears a live stall
    drive('{rs: 1, rt: 5, dst: 5, wr: 1'b1, ld: 1'b1, bub: 1'b0});
    @(posedge clk); #1;
    drive('{rs: 5, rt: 0, dst: 20, wr: 1'b1, ld: 1'b0, bub: 1'b0});
    @(posedge clk); #1;
    drive(nop_m());
    @(negedge clk);
    chk("R7", stall, 1);
    #2 rst_n = 1'b0;
    #1;
    chk("R12", stall, 0);
    chk("R12", pc_we, 1);
    chk("R12", fwd_a, 0);
    finish_run();
  end
endmodule